// File: doc/BRIEF.md
# Update-Only Coherence Cache Controller

This block is the coherence controller of one private cache. It keeps a small direct-mapped table of lines. Each line holds a state, a tag, one data word and the kind of commutative operation it is collecting. Besides the usual Invalid, Shared and Modified states there is a fourth stable state, Update-only. In that state several private caches may each apply commutative add or OR updates to the same address at the same time. Each cache holds only its own partial result, and the shared level combines the partials later.

The core side issues loads, stores, commutative adds and commutative ORs, one at a time, with a valid/ready handshake. A request that the local state can serve completes on the next cycle. Any other request leaves the line Invalid and sends one permission request to the directory. If the line held Modified data or a partial value, that content is written back first. Further core requests stall until the grant arrives. The directory side also sends invalidate and downgrade messages. The controller answers each one on its reply channel one cycle later, carrying full data, a partial value or a plain acknowledge. An address splits into a low index field (log2 of the line count) and a high tag field.

Top module: `coup_cache_ctl`

## Requirements
- R1: After reset every line is Invalid, `req_ready` is 1, and `resp_valid`, `dir_req_valid` and `out_valid` are 0.
- R2: A load that misses raises `dir_req_valid` one cycle after acceptance with `dir_req_kind` 0 (read permission). On the grant the line becomes Shared and `resp_data` returns `grant_data` one cycle later. Loads to a Shared or Modified line then hit without a directory request.
- R3: A store that misses (line not Modified with a matching tag) requests kind 1 (write permission). On the grant the line becomes Modified and holds the store data.
- R4: An add (`req_op` 2) or OR (`req_op` 3) to a line that is Invalid, Shared or held with another tag requests kind 2 (update-only permission), with `dir_req_upd_or` set to 1 for OR and 0 for add. On the grant the line becomes Update-only, starting from the identity value 0 and merged with the operand.
- R5: In Update-only, an update of the same operation is merged locally and completes one cycle later with no directory request. `resp_data` shows the new partial value.
- R6: In Update-only, a load, a store or an update of the other operation flushes the partial value on the reply channel (`out_evict` 1, `out_kind` 2, `out_upd_or` giving the operation). The flush comes in the same cycle as the new directory request.
- R7: A commutative update to a Modified line is applied directly with no directory request. The add wraps modulo 2^DATA_W.
- R8: An invalidate (`snp_kind` 0) gets a reply one cycle later with `out_evict` 0. A Modified line replies with `out_kind` 1 and its full data. An Update-only line replies with `out_kind` 2 and its partial value. Any other case, including a tag mismatch, replies with `out_kind` 0. A matching line ends Invalid.
- R9: A downgrade (`snp_kind` 1) turns a matching Modified line into Shared and returns full data. The line stays readable locally. A matching Update-only line returns its partial value and becomes Invalid. A Shared line, an Invalid line or a tag mismatch gets `out_kind` 0 and no state change.
- R10: `req_ready` is 0 while a directory request is outstanding and in any cycle with `snp_valid` high. A `grant_valid` with nothing outstanding has no effect.
- R11: A miss on a line index that holds a Modified line with another tag writes back the full data (`out_evict` 1, `out_kind` 1, old address) in the cycle of the directory request.
- R12: A request that hits completes with `resp_valid` exactly one cycle after acceptance. For a load, `resp_data` is the line data. For a store or an update, it is the value written.

The directory must not assert `grant_valid` and `snp_valid` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Core request valid |
| req_op | input | 2 | 0 load, 1 store, 2 commutative add, 3 commutative OR |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Store data or update operand |
| req_ready | output | 1 | Request accepted this cycle when valid |
| resp_valid | output | 1 | Request completed |
| resp_data | output | DATA_W | Load data or value written |
| dir_req_valid | output | 1 | Permission request to the directory |
| dir_req_kind | output | 2 | 0 read, 1 write, 2 update-only |
| dir_req_addr | output | ADDR_W | Address of the permission request |
| dir_req_upd_or | output | 1 | Update-only request is for OR (1) or add (0) |
| grant_valid | input | 1 | Directory grant for the outstanding request |
| grant_data | input | DATA_W | Data supplied with a read grant |
| snp_valid | input | 1 | Directory coherence message valid |
| snp_kind | input | 1 | 0 invalidate, 1 downgrade to Shared |
| snp_addr | input | ADDR_W | Address of the coherence message |
| out_valid | output | 1 | Reply or writeback valid |
| out_kind | output | 2 | 0 acknowledge, 1 full data, 2 partial value |
| out_evict | output | 1 | 1 for a writeback caused by a core miss, 0 for a message reply |
| out_addr | output | ADDR_W | Address of the reply or writeback |
| out_data | output | DATA_W | Full data or partial value |
| out_upd_or | output | 1 | Operation of a partial value (1 OR, 0 add) |

## Verification
On every line index, the bench builds each starting state: Invalid, Shared, Modified, Update-only for add and Update-only for OR. It then applies each of the four core operations to that state. The result shows whether the hit/miss decision, the permission kind and the flush of partial values are chosen per state and per operation. The same operation is repeated with a different tag, which separates tag-conflict writebacks from same-address upgrades. A downgrade followed by a load shows the difference between a line that keeps data after downgrade and one that must drop a partial value. Directed cases cover add overflow, an unsolicited grant and the stall during outstanding requests and messages.

// File: rtl/coup_pkg.sv
package coup_pkg;
  typedef enum logic [1:0] {ST_I = 2'd0, ST_S = 2'd1, ST_M = 2'd2, ST_U = 2'd3} lstate_t;
  typedef enum logic [1:0] {OP_LD = 2'd0, OP_ST = 2'd1, OP_CADD = 2'd2, OP_COR = 2'd3} cop_t;
  localparam logic [1:0] GET_S = 2'd0;
  localparam logic [1:0] GET_M = 2'd1;
  localparam logic [1:0] GET_U = 2'd2;
  localparam logic [1:0] RPL_ACK  = 2'd0;
  localparam logic [1:0] RPL_FULL = 2'd1;
  localparam logic [1:0] RPL_PART = 2'd2;
  localparam logic SNP_INV = 1'b0;
  localparam logic SNP_DG  = 1'b1;
endpackage

// File: rtl/coup_update_alu.sv
module coup_update_alu #(
  parameter int DATA_W = 16
) (
  input  logic              is_or,
  input  logic              from_ident,
  input  logic [DATA_W-1:0] acc,
  input  logic [DATA_W-1:0] operand,
  output logic [DATA_W-1:0] result
);
  function automatic logic [DATA_W-1:0] ident(input logic use_or);
    ident = use_or ? '0 : '0;
  endfunction

  function automatic logic [DATA_W-1:0] merge(input logic use_or,
                                              input logic [DATA_W-1:0] a,
                                              input logic [DATA_W-1:0] b);
    merge = use_or ? (a | b) : (a + b);
  endfunction

  assign result = merge(is_or, from_ident ? ident(is_or) : acc, operand);
endmodule

// File: rtl/coup_line_table.sv
module coup_line_table import coup_pkg::*; #(
  parameter int LINES  = 4,
  parameter int TAG_W  = 4,
  parameter int DATA_W = 16,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  a_idx,
  output lstate_t           a_st,
  output logic [TAG_W-1:0]  a_tag,
  output logic [DATA_W-1:0] a_dat,
  output logic              a_or,
  input  logic [IDX_W-1:0]  b_idx,
  output lstate_t           b_st,
  output logic [TAG_W-1:0]  b_tag,
  output logic [DATA_W-1:0] b_dat,
  output logic              b_or,
  input  logic              we,
  input  logic [IDX_W-1:0]  w_idx,
  input  lstate_t           w_st,
  input  logic [TAG_W-1:0]  w_tag,
  input  logic [DATA_W-1:0] w_dat,
  input  logic              w_or
);
  lstate_t           st_q  [LINES];
  logic [TAG_W-1:0]  tag_q [LINES];
  logic [DATA_W-1:0] dat_q [LINES];
  logic              or_q  [LINES];
  logic [LINES-1:0]  wen;

  for (genvar g = 0; g < LINES; g++) begin : g_wdec
    assign wen[g] = we && (w_idx == IDX_W'(g));
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < LINES; k++) begin
      if (!rst_n) begin
        st_q[k]  <= ST_I;
        tag_q[k] <= '0;
        dat_q[k] <= '0;
        or_q[k]  <= 1'b0;
      end else if (wen[k]) begin
        st_q[k]  <= w_st;
        tag_q[k] <= w_tag;
        dat_q[k] <= w_dat;
        or_q[k]  <= w_or;
      end
    end
  end

  assign a_st  = st_q[a_idx];
  assign a_tag = tag_q[a_idx];
  assign a_dat = dat_q[a_idx];
  assign a_or  = or_q[a_idx];
  assign b_st  = st_q[b_idx];
  assign b_tag = tag_q[b_idx];
  assign b_dat = dat_q[b_idx];
  assign b_or  = or_q[b_idx];
endmodule

// File: rtl/coup_mshr.sv
module coup_mshr #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set,
  input  logic              clr,
  input  logic [1:0]        in_op,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_wdata,
  output logic              pend,
  output logic [1:0]        p_op,
  output logic [ADDR_W-1:0] p_addr,
  output logic [DATA_W-1:0] p_wdata
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend    <= 1'b0;
      p_op    <= '0;
      p_addr  <= '0;
      p_wdata <= '0;
    end else if (set) begin
      pend    <= 1'b1;
      p_op    <= in_op;
      p_addr  <= in_addr;
      p_wdata <= in_wdata;
    end else if (clr) begin
      pend    <= 1'b0;
    end
  end
endmodule

// File: rtl/coup_cache_ctl.sv
module coup_cache_ctl import coup_pkg::*; #(
  parameter int LINES  = 4,
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              resp_valid,
  output logic [DATA_W-1:0] resp_data,
  output logic              dir_req_valid,
  output logic [1:0]        dir_req_kind,
  output logic [ADDR_W-1:0] dir_req_addr,
  output logic              dir_req_upd_or,
  input  logic              grant_valid,
  input  logic [DATA_W-1:0] grant_data,
  input  logic              snp_valid,
  input  logic              snp_kind,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              out_valid,
  output logic [1:0]        out_kind,
  output logic              out_evict,
  output logic [ADDR_W-1:0] out_addr,
  output logic [DATA_W-1:0] out_data,
  output logic              out_upd_or
);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - IDX_W;

  // Core-side decode
  logic [IDX_W-1:0] c_idx;
  logic [TAG_W-1:0] c_tag;
  lstate_t a_st, b_st;
  logic [TAG_W-1:0] a_tag, b_tag;
  logic [DATA_W-1:0] a_dat, b_dat;
  logic a_or, b_or;

  assign c_idx = req_addr[IDX_W-1:0];
  assign c_tag = req_addr[ADDR_W-1:IDX_W];

  // Snoop-side decode
  logic [IDX_W-1:0] s_idx;
  logic [TAG_W-1:0] s_tag;
  assign s_idx = snp_addr[IDX_W-1:0];
  assign s_tag = snp_addr[ADDR_W-1:IDX_W];

  // Outstanding request
  logic pend;
  logic [1:0] p_op;
  logic [ADDR_W-1:0] p_addr;
  logic [DATA_W-1:0] p_wdata;

  // Named events
  logic c_match, is_upd, u_or;
  logic hit_read, hit_write, hit_u_local, hit_m_upd, c_hit;
  logic accept, miss_issue, victim_wb, g_take, s_match;
  logic [DATA_W-1:0] alu_core, alu_fill, hit_dat, fill_dat;
  lstate_t fill_st, s_next;
  logic [1:0] s_rpl;

  assign req_ready   = !pend && !snp_valid;
  assign accept      = req_valid && req_ready;
  assign is_upd      = req_op[1];
  assign u_or        = req_op[0];
  assign c_match     = (a_st != ST_I) && (a_tag == c_tag);
  assign hit_read    = (req_op == OP_LD) && c_match && (a_st == ST_S || a_st == ST_M);
  assign hit_write   = (req_op == OP_ST) && c_match && (a_st == ST_M);
  assign hit_u_local = is_upd && c_match && (a_st == ST_U) && (a_or == u_or);
  assign hit_m_upd   = is_upd && c_match && (a_st == ST_M);
  assign c_hit       = hit_read || hit_write || hit_u_local || hit_m_upd;
  assign miss_issue  = accept && !c_hit;
  assign victim_wb   = (a_st == ST_M) || (a_st == ST_U);
  assign g_take      = grant_valid && pend && !snp_valid;
  assign s_match     = (b_st != ST_I) && (b_tag == s_tag);

  coup_update_alu #(.DATA_W(DATA_W)) u_alu_core (
    .is_or(u_or), .from_ident(1'b0), .acc(a_dat), .operand(req_wdata), .result(alu_core)
  );

  coup_update_alu #(.DATA_W(DATA_W)) u_alu_fill (
    .is_or(p_op[0]), .from_ident(1'b1), .acc(grant_data), .operand(p_wdata), .result(alu_fill)
  );

  always_comb begin
    case (req_op)
      OP_LD:   hit_dat = a_dat;
      OP_ST:   hit_dat = req_wdata;
      default: hit_dat = alu_core;
    endcase
    case (p_op)
      OP_LD:   begin fill_st = ST_S; fill_dat = grant_data; end
      OP_ST:   begin fill_st = ST_M; fill_dat = p_wdata;    end
      default: begin fill_st = ST_U; fill_dat = alu_fill;   end
    endcase
  end

  // Snoop outcome
  always_comb begin
    s_rpl  = RPL_ACK;
    s_next = b_st;
    if (s_match) begin
      if (b_st == ST_M) s_rpl = RPL_FULL;
      else if (b_st == ST_U) s_rpl = RPL_PART;
      if (snp_kind == SNP_INV) s_next = ST_I;
      else if (b_st == ST_M) s_next = ST_S;
      else if (b_st == ST_U) s_next = ST_I;
    end
  end

  // Table write selection: message > grant > core
  logic w_en;
  logic [IDX_W-1:0] w_idx;
  lstate_t w_st;
  logic [TAG_W-1:0] w_tag;
  logic [DATA_W-1:0] w_dat;
  logic w_or;

  always_comb begin
    w_en  = 1'b0;
    w_idx = c_idx;
    w_st  = a_st;
    w_tag = a_tag;
    w_dat = a_dat;
    w_or  = a_or;
    if (snp_valid) begin
      w_en  = s_match;
      w_idx = s_idx;
      w_st  = s_next;
      w_tag = b_tag;
      w_dat = b_dat;
      w_or  = b_or;
    end else if (g_take) begin
      w_en  = 1'b1;
      w_idx = p_addr[IDX_W-1:0];
      w_st  = fill_st;
      w_tag = p_addr[ADDR_W-1:IDX_W];
      w_dat = fill_dat;
      w_or  = p_op[0];
    end else if (accept) begin
      w_en  = 1'b1;
      w_st  = c_hit ? a_st : ST_I;
      w_dat = c_hit ? hit_dat : a_dat;
    end
  end

  coup_line_table #(.LINES(LINES), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_table (
    .clk(clk), .rst_n(rst_n),
    .a_idx(c_idx), .a_st(a_st), .a_tag(a_tag), .a_dat(a_dat), .a_or(a_or),
    .b_idx(s_idx), .b_st(b_st), .b_tag(b_tag), .b_dat(b_dat), .b_or(b_or),
    .we(w_en), .w_idx(w_idx), .w_st(w_st), .w_tag(w_tag), .w_dat(w_dat), .w_or(w_or)
  );

  coup_mshr #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mshr (
    .clk(clk), .rst_n(rst_n), .set(miss_issue), .clr(g_take),
    .in_op(req_op), .in_addr(req_addr), .in_wdata(req_wdata),
    .pend(pend), .p_op(p_op), .p_addr(p_addr), .p_wdata(p_wdata)
  );

  // Registered outputs
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid     <= 1'b0;
      resp_data      <= '0;
      dir_req_valid  <= 1'b0;
      dir_req_kind   <= GET_S;
      dir_req_addr   <= '0;
      dir_req_upd_or <= 1'b0;
      out_valid      <= 1'b0;
      out_kind       <= RPL_ACK;
      out_evict      <= 1'b0;
      out_addr       <= '0;
      out_data       <= '0;
      out_upd_or     <= 1'b0;
    end else begin
      resp_valid     <= (accept && c_hit) || g_take;
      resp_data      <= g_take ? fill_dat : hit_dat;
      dir_req_valid  <= miss_issue;
      dir_req_kind   <= is_upd ? GET_U : (req_op == OP_ST ? GET_M : GET_S);
      dir_req_addr   <= req_addr;
      dir_req_upd_or <= is_upd && u_or;
      if (snp_valid) begin
        out_valid  <= 1'b1;
        out_kind   <= s_rpl;
        out_evict  <= 1'b0;
        out_addr   <= snp_addr;
        out_data   <= b_dat;
        out_upd_or <= b_or;
      end else begin
        out_valid  <= miss_issue && victim_wb;
        out_kind   <= (a_st == ST_U) ? RPL_PART : RPL_FULL;
        out_evict  <= 1'b1;
        out_addr   <= {a_tag, c_idx};
        out_data   <= a_dat;
        out_upd_or <= a_or;
      end
    end
  end
endmodule

// File: rtl/coup_cache_chk.sv
module coup_cache_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic resp_valid,
  input logic dir_req_valid,
  input logic grant_valid,
  input logic snp_valid,
  input logic out_valid,
  input logic out_evict,
  input logic hit_u_local,
  input logic pend
);
  // R8
  snoop_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid |=> (out_valid && !out_evict));

  // R5
  u_local_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && hit_u_local) |=> (resp_valid && !dir_req_valid));

  // R10
  stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> !req_ready);

  // R12
  resp_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> ($past(req_valid && req_ready) || $past(grant_valid)));

  // R6
  flush_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_evict) |-> dir_req_valid);

  // R2
  dir_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dir_req_valid |-> ($past(req_valid && req_ready) && pend));
endmodule

bind coup_cache_ctl coup_cache_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .resp_valid(resp_valid), .dir_req_valid(dir_req_valid), .grant_valid(grant_valid),
  .snp_valid(snp_valid), .out_valid(out_valid), .out_evict(out_evict),
  .hit_u_local(hit_u_local), .pend(pend)
);

// File: tb/sim_coup_cache_ctl.sv
module sim_coup_cache_ctl;
  localparam int CLK_PERIOD = 10;
  localparam int NL = 4;
  localparam int AW = 6;
  localparam int DW = 16;
  localparam int TW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] req_op = '0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, resp_valid;
  logic [DW-1:0] resp_data;
  logic dir_req_valid, dir_req_upd_or;
  logic [1:0] dir_req_kind;
  logic [AW-1:0] dir_req_addr;
  logic grant_valid = 1'b0;
  logic [DW-1:0] grant_data = '0;
  logic snp_valid = 1'b0;
  logic snp_kind = 1'b0;
  logic [AW-1:0] snp_addr = '0;
  logic out_valid, out_evict, out_upd_or;
  logic [1:0] out_kind;
  logic [AW-1:0] out_addr;
  logic [DW-1:0] out_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  coup_cache_ctl #(.LINES(NL), .ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_ready(req_ready), .resp_valid(resp_valid), .resp_data(resp_data),
    .dir_req_valid(dir_req_valid), .dir_req_kind(dir_req_kind), .dir_req_addr(dir_req_addr),
    .dir_req_upd_or(dir_req_upd_or), .grant_valid(grant_valid), .grant_data(grant_data),
    .snp_valid(snp_valid), .snp_kind(snp_kind), .snp_addr(snp_addr),
    .out_valid(out_valid), .out_kind(out_kind), .out_evict(out_evict),
    .out_addr(out_addr), .out_data(out_data), .out_upd_or(out_upd_or)
  );

  int n_chk = 0;
  int n_err = 0;

  // Model: 0 Invalid, 1 Shared, 2 Modified, 3 Update-only
  int m_st [NL];
  logic [TW-1:0] m_tag [NL];
  logic [DW-1:0] m_dat [NL];
  logic m_or [NL];

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic core(int op, logic [AW-1:0] a, logic [DW-1:0] wd, logic [DW-1:0] gd);
    int i = int'(a[1:0]);
    logic [TW-1:0] tg = a[AW-1:2];
    bit match = (m_st[i] != 0) && (m_tag[i] == tg);
    bit o = (op == 3);
    bit hit;
    logic [DW-1:0] nd;
    string lbl;
    case (op)
      0: hit = match && (m_st[i] == 1 || m_st[i] == 2);
      1: hit = match && (m_st[i] == 2);
      default: hit = match && (m_st[i] == 2 || (m_st[i] == 3 && m_or[i] == o));
    endcase
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'(op); req_addr = a; req_wdata = wd;
    #1;
    chk("R10 ready when idle", 32'(req_ready), 32'd1);
    @(negedge clk);
    req_valid = 1'b0;
    if (hit) begin
      if (op == 0) nd = m_dat[i];
      else if (op == 1) nd = wd;
      else nd = o ? (m_dat[i] | wd) : DW'(m_dat[i] + wd);
      lbl = (op >= 2) ? ((m_st[i] == 3) ? "R5 local update" : "R7 update on Modified")
                      : "R12 hit";
      chk(lbl, 32'(dir_req_valid), 32'd0);
      chk("R12 resp after hit", 32'(resp_valid), 32'd1);
      chk("R12 hit data", 32'(resp_data), 32'(nd));
      m_dat[i] = nd;
    end else begin
      lbl = (op == 0) ? "R2 read request" : (op == 1) ? "R3 write request" : "R4 update request";
      chk(lbl, 32'(dir_req_valid), 32'd1);
      chk(lbl, 32'(dir_req_kind), (op >= 2) ? 32'd2 : 32'(op));
      chk(lbl, 32'(dir_req_addr), 32'(a));
      if (op >= 2) chk("R4 op bit", 32'(dir_req_upd_or), 32'(o));
      if (m_st[i] == 3) begin
        chk("R6 flush", 32'(out_valid), 32'd1);
        chk("R6 flush kind", 32'(out_kind), 32'd2);
        chk("R6 flush evict", 32'(out_evict), 32'd1);
        chk("R6 flush data", 32'(out_data), 32'(m_dat[i]));
        chk("R6 flush op", 32'(out_upd_or), 32'(m_or[i]));
        chk("R6 flush addr", 32'(out_addr), 32'({m_tag[i], 2'(i)}));
      end else if (m_st[i] == 2) begin
        chk("R11 writeback", 32'(out_valid), 32'd1);
        chk("R11 writeback kind", 32'(out_kind), 32'd1);
        chk("R11 writeback evict", 32'(out_evict), 32'd1);
        chk("R11 writeback data", 32'(out_data), 32'(m_dat[i]));
        chk("R11 writeback addr", 32'(out_addr), 32'({m_tag[i], 2'(i)}));
      end else begin
        chk("R6 no writeback from I or S", 32'(out_valid), 32'd0);
      end
      chk("R10 stall while outstanding", 32'(req_ready), 32'd0);
      chk(lbl, 32'(resp_valid), 32'd0);
      grant_valid = 1'b1; grant_data = gd;
      @(negedge clk);
      grant_valid = 1'b0;
      nd = (op == 0) ? gd : wd;
      chk(lbl, 32'(resp_valid), 32'd1);
      chk(lbl, 32'(resp_data), 32'(nd));
      m_st[i] = (op == 0) ? 1 : (op == 1) ? 2 : 3;
      m_tag[i] = tg; m_dat[i] = nd; m_or[i] = o;
    end
  endtask

  task automatic snoop(bit k, logic [AW-1:0] a);
    int i = int'(a[1:0]);
    bit match = (m_st[i] != 0) && (m_tag[i] == a[AW-1:2]);
    string lbl = k ? "R9 downgrade" : "R8 invalidate";
    int ek = 0;
    if (match && m_st[i] == 2) ek = 1;
    if (match && m_st[i] == 3) ek = 2;
    @(negedge clk);
    snp_valid = 1'b1; snp_kind = k; snp_addr = a;
    #1;
    chk("R10 stall during message", 32'(req_ready), 32'd0);
    @(negedge clk);
    snp_valid = 1'b0;
    chk(lbl, 32'(out_valid), 32'd1);
    chk(lbl, 32'(out_evict), 32'd0);
    chk(lbl, 32'(out_kind), 32'(ek));
    if (ek != 0) chk(lbl, 32'(out_data), 32'(m_dat[i]));
    if (ek == 2) chk(lbl, 32'(out_upd_or), 32'(m_or[i]));
    if (match) begin
      if (!k) m_st[i] = 0;
      else if (m_st[i] == 2) m_st[i] = 1;
      else if (m_st[i] == 3) m_st[i] = 0;
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    for (int k = 0; k < NL; k++) begin
      m_st[k] = 0; m_tag[k] = '0; m_dat[k] = '0; m_or[k] = 1'b0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 ready", 32'(req_ready), 32'd1);
    chk("R1 resp", 32'(resp_valid), 32'd0);
    chk("R1 dir", 32'(dir_req_valid), 32'd0);
    chk("R1 out", 32'(out_valid), 32'd0);
    for (int i = 0; i < NL; i++) snoop(1'b0, AW'({4'd3, 2'(i)}));

    // Unsolicited grant has no effect (R10)
    grant_valid = 1'b1; grant_data = 16'hDEAD;
    @(negedge clk);
    grant_valid = 1'b0;
    chk("R10 stray grant no resp", 32'(resp_valid), 32'd0);
    core(0, AW'({4'd2, 2'd1}), 16'h0, 16'h0BEE);

    // R7 wraparound of add on a Modified line
    core(1, AW'({4'd5, 2'd2}), 16'hFFF0, 16'h0);
    core(2, AW'({4'd5, 2'd2}), 16'h0020, 16'h0);
    chk("R7 add wraps", 32'(resp_data), 32'h0010);

    // Sweep: line x start state x operation
    for (int i = 0; i < NL; i++) begin
      for (int s = 0; s < 5; s++) begin
        for (int op = 0; op < 4; op++) begin
          logic [TW-1:0] ta = TW'(i + s + op);
          logic [AW-1:0] aa = {ta, 2'(i)};
          logic [AW-1:0] ab = {TW'(ta + 4'd7), 2'(i)};
          logic [DW-1:0] base = DW'(i * 1000 + s * 97 + op * 13 + 5);
          snoop(1'b0, aa);
          if (s > 0) core(s - 1, aa, base, DW'(base ^ 16'h5A5A));
          core(op, aa, DW'(base + 16'h0111), DW'(base ^ 16'h0F0F));
          core(op, aa, DW'(base + 16'h0222), DW'(base ^ 16'h3C3C));
          snoop(1'b1, aa);
          core(0, aa, 16'h0, DW'(base + 16'h4000));
          core(op, ab, DW'(base + 16'h0333), DW'(base ^ 16'h7777));
          snoop(1'b1, ab);
          snoop(1'b0, ab);
        end
      end
    end
    finish_run();
  end
endmodule